// File: doc/BRIEF.md
# ADC Channel Scan Sequencer

This block produces the order in which the analog channels of a multi-channel converter are sampled. The host sets a 4-bit scan pattern code, a 4-bit start/stop channel number N and a 16-bit per-channel selection mask, then pulses `start_i`. The sequencer captures a set of enabled channels for the whole scan. It presents the lowest remaining channel on `ch_o` while `busy_o` is high, and moves to the next higher enabled channel on each advance event.

In the external-clock patterns an advance event is a pulse on `ext_strobe_i`. In the internal-clock patterns it is a pulse on `int_done_i`, from the converter's own timing, so the host does nothing more. `last_o` marks the final channel of the scan. `done_o` pulses for one cycle when the scan ends. `result_cnt_o` tells the result store how many conversions to expect. `avg_en_o` passes the host's averaging request on only when the captured pattern runs on the internal clock. The parameter `NUM_CH` sizes the block for an 8- or 16-channel device.

Top module: `adc_scan_sequencer`

## Requirements
- R1: After reset `busy_o`, `last_o`, `done_o`, `invalid_o` and `avg_en_o` are low and `result_cnt_o` is zero.
- R2: Code 4'b0100 (external clock) scans channels 0 up to N in ascending order and sets `result_cnt_o` to N+1. The first channel is on `ch_o` with `busy_o` high in the first cycle after the clock edge that samples `start_i`.
- R3: Codes 4'b0101 (internal clock) and 4'b0110 (external clock) scan channels N up to NUM_CH-1 in ascending order, with `result_cnt_o` = NUM_CH-N.
- R4: Codes 4'b0111 (internal clock) and 4'b1000 (external clock) scan every channel i with mask bit i set, in ascending order. `result_cnt_o` equals the number of set bits. Mask bits at or above NUM_CH are ignored.
- R5: In external-clock patterns only `ext_strobe_i` advances the scan, and in internal-clock patterns only `int_done_i` does. The other input leaves `ch_o` unchanged.
- R6: `last_o` is high exactly while the final channel of the scan is on `ch_o`.
- R7: The advance event taken with `last_o` high ends the scan: in the next cycle `busy_o` is low and `done_o` is high for that one cycle. Advance events while idle change nothing.
- R8: Any code other than the five above starts no conversions. `invalid_o` goes high, `result_cnt_o` is zero and `done_o` pulses, and this state holds until the next accepted start.
- R9: In patterns 4'b0100, 4'b0101 and 4'b0110 an N of NUM_CH or more, or an empty effective mask in the custom patterns, gives an immediate `done_o` pulse with `result_cnt_o` zero, no busy cycle and `invalid_o` low.
- R10: `avg_en_o` equals `avg_req_i` when the captured code is 4'b0101 or 4'b0111, and is low for every other code.
- R11: A start pulse while `busy_o` is high is ignored. The scan, its channel order and `result_cnt_o` continue unchanged.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| start_i | input | 1 | Start pulse, accepted only when idle |
| mode_i | input | 4 | Scan pattern code |
| chsel_i | input | 4 | Channel number N |
| custom_mask_i | input | 16 | Per-channel enable for the custom patterns, bit i = channel i |
| avg_req_i | input | 1 | Host request for averaging |
| ext_strobe_i | input | 1 | External conversion strobe |
| int_done_i | input | 1 | Internal conversion-done pulse |
| busy_o | output | 1 | A scan is in progress and `ch_o` is valid |
| ch_o | output | $clog2(NUM_CH) | Channel index to convert |
| last_o | output | 1 | `ch_o` is the final channel of the scan |
| done_o | output | 1 | One-cycle pulse at the end of a scan |
| result_cnt_o | output | $clog2(NUM_CH+1) | Number of results the scan produces |
| invalid_o | output | 1 | The captured code is not a supported pattern |
| avg_en_o | output | 1 | Averaging enable, gated by clock mode |

## Verification
The bench builds two copies side by side, one with NUM_CH=16 and one with NUM_CH=8, and drives both from the same inputs. On the 8-channel copy, N values of 8 to 15 and mask bits in the upper byte reach the empty-scan path and the ignored-mask-bit path. On the 16-channel copy the same stimulus gives long scans that run to the top channel. Because the two copies finish at different times, each scan also checks that a copy which is already idle ignores the remaining strobes.

// File: rtl/scan_seq_pkg.sv
package scan_seq_pkg;

   localparam int MAX_CH  = 16;
   localparam int CODE_W  = 4;

   typedef enum logic [CODE_W-1:0] {
      MODE_LOW_EXT  = 4'b0100,
      MODE_HIGH_INT = 4'b0101,
      MODE_HIGH_EXT = 4'b0110,
      MODE_LIST_INT = 4'b0111,
      MODE_LIST_EXT = 4'b1000
   } scan_mode_e;

   typedef enum logic [1:0] {
      PAT_NONE,
      PAT_LOW,
      PAT_HIGH,
      PAT_LIST
   } pattern_e;

   typedef struct packed {
      pattern_e pat;
      logic     int_clk;
      logic     legal;
   } mode_info_t;

   function automatic mode_info_t decode_mode(logic [CODE_W-1:0] code);
      mode_info_t info;
      info = '{pat: PAT_NONE, int_clk: 1'b0, legal: 1'b0};
      case (code)
         MODE_LOW_EXT:  info = '{pat: PAT_LOW,  int_clk: 1'b0, legal: 1'b1};
         MODE_HIGH_INT: info = '{pat: PAT_HIGH, int_clk: 1'b1, legal: 1'b1};
         MODE_HIGH_EXT: info = '{pat: PAT_HIGH, int_clk: 1'b0, legal: 1'b1};
         MODE_LIST_INT: info = '{pat: PAT_LIST, int_clk: 1'b1, legal: 1'b1};
         MODE_LIST_EXT: info = '{pat: PAT_LIST, int_clk: 1'b0, legal: 1'b1};
         default:       info = '{pat: PAT_NONE, int_clk: 1'b0, legal: 1'b0};
      endcase
      return info;
   endfunction

endpackage

// File: rtl/scan_mask_gen.sv
module scan_mask_gen
   import scan_seq_pkg::*;
#(
   parameter int NUM_CH = 16
)(
   input  mode_info_t        info_i,
   input  logic [3:0]        sel_i,
   input  logic [MAX_CH-1:0] list_i,
   output logic [NUM_CH-1:0] vec_o
);

   logic sel_in_range;
   assign sel_in_range = (int'(sel_i) < NUM_CH);

   for (genvar i = 0; i < NUM_CH; i++) begin : g_bit
      always_comb begin
         case (info_i.pat)
            PAT_LOW:  vec_o[i] = sel_in_range && (i <= int'(sel_i));
            PAT_HIGH: vec_o[i] = (i >= int'(sel_i));
            PAT_LIST: vec_o[i] = list_i[i];
            default:  vec_o[i] = 1'b0;
         endcase
      end
   end

   if (NUM_CH < MAX_CH) begin : g_unused_list
      logic unused_hi;
      assign unused_hi = ^list_i[MAX_CH-1:NUM_CH];
   end

endmodule

// File: rtl/scan_popcount.sv
module scan_popcount #(
   parameter int W     = 16,
   parameter int CNT_W = $clog2(W+1)
)(
   input  logic [W-1:0]     vec_i,
   output logic [CNT_W-1:0] cnt_o
);

   always_comb begin
      cnt_o = '0;
      for (int i = 0; i < W; i++) begin
         cnt_o = cnt_o + CNT_W'(vec_i[i]);
      end
   end

endmodule

// File: rtl/scan_lowest_pick.sv
module scan_lowest_pick #(
   parameter int NUM_CH = 16,
   parameter int CH_W   = $clog2(NUM_CH)
)(
   input  logic [NUM_CH-1:0] rem_i,
   output logic [CH_W-1:0]   idx_o,
   output logic              any_o,
   output logic              single_o
);

   localparam logic [NUM_CH-1:0] ONE = NUM_CH'(1);

   always_comb begin
      idx_o = '0;
      for (int i = NUM_CH-1; i >= 0; i--) begin
         if (rem_i[i]) idx_o = CH_W'(i);
      end
   end

   assign any_o    = |rem_i;
   assign single_o = any_o && ((rem_i & (rem_i - ONE)) == '0);

endmodule

// File: rtl/adc_scan_sequencer.sv
module adc_scan_sequencer
   import scan_seq_pkg::*;
#(
   parameter int NUM_CH = 16,
   localparam int CH_W  = $clog2(NUM_CH),
   localparam int CNT_W = $clog2(NUM_CH+1)
)(
   input  logic              clk_i,
   input  logic              rst_ni,
   input  logic              start_i,
   input  logic [3:0]        mode_i,
   input  logic [3:0]        chsel_i,
   input  logic [MAX_CH-1:0] custom_mask_i,
   input  logic              avg_req_i,
   input  logic              ext_strobe_i,
   input  logic              int_done_i,
   output logic              busy_o,
   output logic [CH_W-1:0]   ch_o,
   output logic              last_o,
   output logic              done_o,
   output logic [CNT_W-1:0]  result_cnt_o,
   output logic              invalid_o,
   output logic              avg_en_o
);

   if (!(NUM_CH == 8 || NUM_CH == 16)) begin : g_bad_num_ch
      $error("adc_scan_sequencer: NUM_CH must be 8 or 16");
   end

   localparam logic [NUM_CH-1:0] ONE = NUM_CH'(1);

   mode_info_t          info_d;
   logic [NUM_CH-1:0]   vec_d;
   logic [CNT_W-1:0]    cnt_d;
   logic [NUM_CH-1:0]   rem_q;
   logic [CNT_W-1:0]    cnt_q;
   logic                int_q;
   logic                ext_q;
   logic                invalid_q;
   logic                done_q;
   logic                accept;
   logic                adv;
   logic                busy;
   logic                last;
   logic [CH_W-1:0]     cur_ch;

   assign info_d = decode_mode(mode_i);

   scan_mask_gen #(.NUM_CH(NUM_CH)) u_mask (
      .info_i (info_d),
      .sel_i  (chsel_i),
      .list_i (custom_mask_i),
      .vec_o  (vec_d)
   );

   scan_popcount #(.W(NUM_CH), .CNT_W(CNT_W)) u_count (
      .vec_i (vec_d),
      .cnt_o (cnt_d)
   );

   scan_lowest_pick #(.NUM_CH(NUM_CH), .CH_W(CH_W)) u_pick (
      .rem_i    (rem_q),
      .idx_o    (cur_ch),
      .any_o    (busy),
      .single_o (last)
   );

   assign accept = start_i && !busy;
   assign adv    = busy && (int_q ? int_done_i : ext_strobe_i);

   always_ff @(posedge clk_i or negedge rst_ni) begin
      if (!rst_ni) begin
         rem_q     <= '0;
         cnt_q     <= '0;
         int_q     <= 1'b0;
         ext_q     <= 1'b0;
         invalid_q <= 1'b0;
         done_q    <= 1'b0;
      end else begin
         done_q <= 1'b0;
         if (accept) begin
            rem_q     <= vec_d;
            cnt_q     <= cnt_d;
            int_q     <= info_d.legal && info_d.int_clk;
            ext_q     <= info_d.legal && !info_d.int_clk;
            invalid_q <= !info_d.legal;
            done_q    <= (vec_d == '0);
         end else if (adv) begin
            rem_q  <= rem_q & ~(ONE << cur_ch);
            done_q <= last;
         end
      end
   end

   assign busy_o       = busy;
   assign ch_o         = cur_ch;
   assign last_o       = last;
   assign done_o       = done_q;
   assign result_cnt_o = cnt_q;
   assign invalid_o    = invalid_q;
   assign avg_en_o     = avg_req_i && int_q;

   AST_LAST_WHILE_BUSY: assert property (@(posedge clk_i) disable iff (!rst_ni)
      last_o |-> busy_o); // R6
   AST_HOLD_WITHOUT_EVENT: assert property (@(posedge clk_i) disable iff (!rst_ni)
      (busy_o && !adv) |=> (busy_o && $stable(ch_o))); // R5
   AST_ASCENDING_ORDER: assert property (@(posedge clk_i) disable iff (!rst_ni)
      (busy_o && adv && !last_o) |=> (busy_o && (ch_o > $past(ch_o)))); // R2
   AST_END_AFTER_LAST: assert property (@(posedge clk_i) disable iff (!rst_ni)
      (busy_o && adv && last_o) |=> (!busy_o && done_o)); // R7
   AST_INVALID_IDLE: assert property (@(posedge clk_i) disable iff (!rst_ni)
      invalid_o |-> (!busy_o && (result_cnt_o == '0))); // R8
   AST_EXT_NO_AVG: assert property (@(posedge clk_i) disable iff (!rst_ni)
      ext_q |-> !avg_en_o); // R10
   AST_START_WHILE_BUSY: assert property (@(posedge clk_i) disable iff (!rst_ni)
      (busy_o && start_i) |=> $stable(result_cnt_o)); // R11

endmodule

// File: tb/adc_scan_sequencer_tb_top.sv
`timescale 1ns/1ps
module adc_scan_sequencer_tb_top;

   logic        clk = 1'b0;
   logic        rst_n = 1'b0;
   logic        start = 1'b0;
   logic [3:0]  mode = 4'd0;
   logic [3:0]  chsel = 4'd0;
   logic [15:0] cmask = 16'd0;
   logic        avg_req = 1'b0;
   logic        ext_stb = 1'b0;
   logic        int_dn = 1'b0;

   logic        busy_a, last_a, done_a, inv_a, avg_a;
   logic [3:0]  ch_a;
   logic [4:0]  cnt_a;
   logic        busy_b, last_b, done_b, inv_b, avg_b;
   logic [2:0]  ch_b;
   logic [3:0]  cnt_b;

   int n_chk = 0;
   int n_err = 0;
   bit finished = 1'b0;
   logic [15:0] exp_rem [2];
   bit          exp_done [2];
   int          nch [2] = '{16, 8};

   always #10 clk = ~clk;

   adc_scan_sequencer #(.NUM_CH(16)) dut_i (
      .clk_i(clk), .rst_ni(rst_n), .start_i(start), .mode_i(mode), .chsel_i(chsel),
      .custom_mask_i(cmask), .avg_req_i(avg_req), .ext_strobe_i(ext_stb), .int_done_i(int_dn),
      .busy_o(busy_a), .ch_o(ch_a), .last_o(last_a), .done_o(done_a),
      .result_cnt_o(cnt_a), .invalid_o(inv_a), .avg_en_o(avg_a));

   adc_scan_sequencer #(.NUM_CH(8)) dut8_i (
      .clk_i(clk), .rst_ni(rst_n), .start_i(start), .mode_i(mode), .chsel_i(chsel),
      .custom_mask_i(cmask), .avg_req_i(avg_req), .ext_strobe_i(ext_stb), .int_done_i(int_dn),
      .busy_o(busy_b), .ch_o(ch_b), .last_o(last_b), .done_o(done_b),
      .result_cnt_o(cnt_b), .invalid_o(inv_b), .avg_en_o(avg_b));

   function automatic bit is_legal(int m);
      return (m >= 4 && m <= 8);
   endfunction

   function automatic bit is_int(int m);
      return (m == 5 || m == 7);
   endfunction

   function automatic logic [15:0] exp_vec(int m, int n, logic [15:0] msk, int nc);
      logic [15:0] v = '0;
      for (int i = 0; i < nc; i++) begin
         case (m)
            4:    v[i] = (n < nc) && (i <= n);
            5, 6: v[i] = (i >= n);
            7, 8: v[i] = msk[i];
            default: v[i] = 1'b0;
         endcase
      end
      return v;
   endfunction

   function automatic int popc(logic [15:0] v);
      int c = 0;
      for (int i = 0; i < 16; i++) c += int'(v[i]);
      return c;
   endfunction

   function automatic int low_idx(logic [15:0] v);
      for (int i = 0; i < 16; i++) if (v[i]) return i;
      return 0;
   endfunction

   function automatic string mode_tag(int m);
      if (m == 4) return "R2";
      if (m == 5 || m == 6) return "R3";
      if (m == 7 || m == 8) return "R4";
      return "R8";
   endfunction

   task automatic chk(string r, string what, int act, int expv);
      n_chk++;
      if (act !== expv) begin
         n_err++;
         $display("FAIL %s %s: actual %0d expected %0d", r, what, act, expv);
      end
   endtask

   task automatic check_one(string r, int k, int b, int c, int l, int d);
      string s = (k == 0) ? "ch16" : "ch8";
      chk(r, {s, " busy"}, b, int'(exp_rem[k] != 0));
      if (exp_rem[k] != 0) chk(r, {s, " channel"}, c, low_idx(exp_rem[k]));
      chk("R6", {s, " last"}, l, int'(popc(exp_rem[k]) == 1));
      chk("R7", {s, " done"}, d, int'(exp_done[k]));
   endtask

   task automatic verify(string r);
      check_one(r, 0, int'(busy_a), int'(ch_a), int'(last_a), int'(done_a));
      check_one(r, 1, int'(busy_b), int'(ch_b), int'(last_b), int'(done_b));
   endtask

   task automatic pulse(bit ext, bit intl);
      @(negedge clk);
      ext_stb = ext;
      int_dn  = intl;
      @(negedge clk);
      ext_stb = 1'b0;
      int_dn  = 1'b0;
   endtask

   task automatic advance_model();
      for (int k = 0; k < 2; k++) begin
         if (exp_rem[k] != 0) begin
            exp_done[k] = (popc(exp_rem[k]) == 1);
            exp_rem[k]  = exp_rem[k] & (exp_rem[k] - 16'd1);
         end else begin
            exp_done[k] = 1'b0;
         end
      end
   endtask

   task automatic run_scan(int m, int n, logic [15:0] msk, bit avg, bit noise, bit restart);
      string tg = mode_tag(m);
      logic [15:0] v;
      bit ext_ev = !is_int(m);
      @(negedge clk);
      mode = 4'(m); chsel = 4'(n); cmask = msk; avg_req = avg; start = 1'b1;
      @(negedge clk);
      start = 1'b0;
      for (int k = 0; k < 2; k++) begin
         v = exp_vec(m, n, msk, nch[k]);
         exp_rem[k]  = v;
         exp_done[k] = (v == 0);
      end
      verify(tg);
      chk(tg, "count16", int'(cnt_a), popc(exp_rem[0]));
      chk(tg, "count8", int'(cnt_b), popc(exp_rem[1]));
      chk("R8", "invalid16", int'(inv_a), int'(!is_legal(m)));
      chk("R8", "invalid8", int'(inv_b), int'(!is_legal(m)));
      chk("R10", "avg16", int'(avg_a), int'(avg && is_int(m)));
      chk("R10", "avg8", int'(avg_b), int'(avg && is_int(m)));
      if (restart && exp_rem[0] != 0 && exp_rem[1] != 0) begin
         @(negedge clk);
         mode = 4'b0101; chsel = 4'd0; start = 1'b1;
         @(negedge clk);
         start = 1'b0;
         exp_done[0] = 1'b0; exp_done[1] = 1'b0;
         verify("R11");
         chk("R11", "count16 kept", int'(cnt_a), popc(exp_vec(m, n, msk, 16)));
         chk("R11", "count8 kept", int'(cnt_b), popc(exp_vec(m, n, msk, 8)));
      end
      while ((exp_rem[0] | exp_rem[1]) != 0) begin
         if (noise) begin
            pulse(!ext_ev, ext_ev);
            exp_done[0] = 1'b0; exp_done[1] = 1'b0;
            verify("R5");
         end
         pulse(ext_ev, !ext_ev);
         advance_model();
         verify(tg);
      end
      pulse(1'b1, 1'b1);
      exp_done[0] = 1'b0; exp_done[1] = 1'b0;
      verify(is_legal(m) ? "R7" : "R8");
      if (is_legal(m)) begin
         chk("R9", "invalid16 low", int'(inv_a), 0);
      end
   endtask

   initial begin
      repeat (100000) @(posedge clk);
      if (!finished) begin
         n_err++;
         $display("FAIL watchdog: actual timeout expected completion");
         $display("Simulation finished: %0d checks, %0d errors", n_chk, n_err);
         $finish;
      end
   end

   initial begin
      void'($urandom(32'd2024));
      repeat (3) @(negedge clk);
      exp_rem[0] = '0; exp_rem[1] = '0; exp_done[0] = 1'b0; exp_done[1] = 1'b0;
      verify("R1");
      chk("R1", "count16", int'(cnt_a), 0);
      chk("R1", "invalid16", int'(inv_a), 0);
      chk("R1", "avg16", int'(avg_a), 0);
      rst_n = 1'b1;
      @(negedge clk);
      avg_req = 1'b1;
      chk("R1", "avg idle", int'(avg_a) | int'(avg_b), 0);

      run_scan(4, 5, 16'h0000, 1'b1, 1'b1, 1'b1);
      run_scan(4, 12, 16'h0000, 1'b0, 1'b0, 1'b0);
      run_scan(5, 9, 16'h0000, 1'b1, 1'b1, 1'b0);
      run_scan(6, 0, 16'h0000, 1'b1, 1'b0, 1'b1);
      run_scan(6, 15, 16'h0000, 1'b0, 1'b1, 1'b0);
      run_scan(7, 0, 16'hFF00, 1'b1, 1'b1, 1'b0);
      run_scan(8, 0, 16'h8181, 1'b1, 1'b1, 1'b1);
      run_scan(8, 3, 16'h0000, 1'b0, 1'b0, 1'b0);
      run_scan(0, 3, 16'hFFFF, 1'b1, 1'b1, 1'b0);
      run_scan(15, 0, 16'hFFFF, 1'b1, 1'b0, 1'b0);
      run_scan(9, 2, 16'h00FF, 1'b1, 1'b0, 1'b0);

      for (int t = 0; t < 60; t++) begin
         int r = int'($urandom_range(0, 6));
         int m = (r <= 4) ? (r + 4) : int'($urandom_range(0, 15));
         run_scan(m, int'($urandom_range(0, 15)), 16'($urandom()),
                  1'($urandom()), 1'($urandom()), 1'($urandom()));
      end

      finished = 1'b1;
      $display("Simulation finished: %0d checks, %0d errors", n_chk, n_err);
      $finish;
   end

endmodule